// File: doc/BRIEF.md
# Instruction Signature Control-Flow Monitor

This block sits next to a processor pipeline and receives one beat for each instruction that retires. Each beat carries the 32-bit instruction word, two flags and a 32-bit operand. The monitor folds every accepted instruction word into a running 32-bit signature using a CRC with the Castagnoli polynomial. Because the fold happens in hardware, any skipped, repeated or corrupted instruction changes the signature.

Where control-flow paths join, the compiler places an update instruction. Its operand is a patch constant that is XORed into the signature, so that every legal predecessor path leaves the same value. A check instruction carries the value the signature should hold at that point. If the two differ, a sticky alarm is raised.

The input is a valid/ready stream. The monitor never applies back-pressure once it is running: `in_ready` is low during reset and in the first cycle after reset, and high from then on. A beat counts only on a cycle where `in_valid` and `in_ready` are both high. Stalled or flushed pipeline slots are sent with `in_valid` low.

Top module: `cfsig_monitor`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `sig_out` is 0x00000000 and `alarm` is 0.
- R2: On each accepted beat, the new signature is the old one XORed with `in_insn`. That value is then shifted right 32 times, one bit at a time, and after each shift 0x82F63B78 is XORed in whenever the bit shifted out was 1. There is no final inversion.
- R3: `in_ready` is 0 during reset and 1 from the first clock edge after reset is released. On any cycle without an accepted beat, `sig_out` keeps its value, whatever the other inputs carry.
- R4: On an accepted beat with `in_is_update` set, `in_operand` is XORed into the signature after the instruction word has been folded in.
- R5: On an accepted beat with `in_is_check` set, `in_operand` is compared with the signature held before that beat. A mismatch sets `alarm` on the next cycle. A match leaves `alarm` unchanged.
- R6: The word of a check beat is itself folded into the signature after the comparison, so the resulting signature is the R2 fold of the pre-beat value.
- R7: Once set, `alarm` stays 1 until reset, even through later matching checks and idle cycles.
- R8: When both flags are set on one beat, the comparison uses the pre-beat signature. The next signature is the fold followed by the XOR with the operand.
- R9: On a beat with neither flag set, `in_operand` has no effect on `sig_out` or `alarm`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A retired instruction is present |
| in_ready | output | 1 | Monitor accepts beats |
| in_insn | input | 32 | Instruction word |
| in_is_update | input | 1 | Beat is a patch update |
| in_is_check | input | 1 | Beat is a signature check |
| in_operand | input | 32 | Patch value or expected signature |
| sig_out | output | 32 | Running signature |
| alarm | output | 1 | Sticky fault alarm |

## Verification
A single beat can carry both the check and the update flag. The bench sends such beats with an operand that matches the pre-beat signature and with one that does not. It then judges two things: the alarm must depend only on the pre-beat comparison, and the signature must equal the fold followed by the patch. A mismatching check is also followed by matching checks and idle cycles, to show that the alarm does not clear. Stall cycles carry garbage words and flags with `in_valid` low, and the signature must stay the same through them.

// File: rtl/cfsig_pkg.sv
package cfsig_pkg;
  localparam int unsigned SIG_W = 32;
  localparam logic [SIG_W-1:0] CASTAGNOLI_REFL = 32'h82F63B78;

  typedef logic [SIG_W-1:0] sig_t;

  // beat kind, indexed by {check, update}
  typedef enum logic [1:0] {
    BEAT_PLAIN  = 2'b00,
    BEAT_UPDATE = 2'b01,
    BEAT_CHECK  = 2'b10,
    BEAT_BOTH   = 2'b11
  } beat_kind_e;
endpackage

// File: rtl/cfsig_fold.sv
module cfsig_fold #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] POLY = 32'h82F63B78
) (
  input  logic [W-1:0] state_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] stage [W+1];

  assign stage[0] = state_i ^ word_i;

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign stage[g+1] = stage[g][0] ? ((stage[g] >> 1) ^ POLY) : (stage[g] >> 1);
  end

  assign state_o = stage[W];
endmodule

// File: rtl/cfsig_sigreg.sv
module cfsig_sigreg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] next_i,
  output logic [W-1:0] sig_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      sig_o <= INIT;
    else if (load_i) sig_o <= next_i;
  end
endmodule

// File: rtl/cfsig_alarm.sv
module cfsig_alarm #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_en_i,
  input  logic [W-1:0] actual_i,
  input  logic [W-1:0] expect_i,
  output logic         alarm_o
);
  logic miss;
  assign miss = cmp_en_i && (actual_i != expect_i);

  always_ff @(posedge clk) begin
    if (!rst_n)    alarm_o <= 1'b0;
    else if (miss) alarm_o <= 1'b1;
  end
endmodule

// File: rtl/cfsig_monitor.sv
module cfsig_monitor
  import cfsig_pkg::*;
#(
  parameter int unsigned W = SIG_W,
  parameter logic [W-1:0] POLY = CASTAGNOLI_REFL,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_insn,
  input  logic         in_is_update,
  input  logic         in_is_check,
  input  logic [W-1:0] in_operand,
  output logic [W-1:0] sig_out,
  output logic         alarm
);
  logic         run_q;
  logic         accept;
  beat_kind_e   kind;
  logic [W-1:0] folded;
  logic [W-1:0] next_sig;
  logic [W-1:0] patch;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  assign in_ready = run_q;
  assign accept   = in_valid && run_q;
  assign kind     = beat_kind_e'({in_is_check, in_is_update});

  cfsig_fold #(.W(W), .POLY(POLY)) u_fold (
    .state_i (sig_out),
    .word_i  (in_insn),
    .state_o (folded)
  );

  always_comb begin
    unique case (kind)
      BEAT_UPDATE, BEAT_BOTH: patch = in_operand;
      default:                patch = '0;
    endcase
  end

  assign next_sig = folded ^ patch;

  cfsig_sigreg #(.W(W), .INIT(INIT)) u_sig (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .next_i (next_sig),
    .sig_o  (sig_out)
  );

  cfsig_alarm #(.W(W)) u_alarm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_en_i (accept && ((kind == BEAT_CHECK) || (kind == BEAT_BOTH))),
    .actual_i (sig_out),
    .expect_i (in_operand),
    .alarm_o  (alarm)
  );
endmodule

// File: rtl/cfsig_monitor_chk.sv
module cfsig_monitor_chk #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] INIT = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_insn,
  input logic         in_is_update,
  input logic         in_is_check,
  input logic [W-1:0] in_operand,
  input logic [W-1:0] sig_out,
  input logic         alarm
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (sig_out == INIT && !alarm && !in_ready)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(sig_out)); // R3

  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> alarm); // R7

  AST_ALARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm && !(acc && in_is_check && in_operand != sig_out)) |=> !alarm); // R5

  AST_MISS_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_is_check && in_operand != sig_out) |=> alarm); // R5

  AST_READY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready); // R3
endmodule

bind cfsig_monitor cfsig_monitor_chk #(.W(W), .INIT(INIT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_insn      (in_insn),
  .in_is_update (in_is_update),
  .in_is_check  (in_is_check),
  .in_operand   (in_operand),
  .sig_out      (sig_out),
  .alarm        (alarm)
);

// File: tb/cfsig_monitor_bench.sv
`timescale 1ns/1ps
module cfsig_monitor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn = '0;
  logic        in_is_update = 1'b0;
  logic        in_is_check = 1'b0;
  logic [31:0] in_operand = '0;
  logic [31:0] sig_out;
  logic        alarm;

  int total = 0;
  int bad = 0;
  logic finished = 1'b0;
  logic [31:0] model_sig = '0;
  logic        model_alarm = 1'b0;

  always #4 clk = ~clk;

  cfsig_monitor u_cfsig_monitor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_is_update(in_is_update), .in_is_check(in_is_check),
    .in_operand(in_operand), .sig_out(sig_out), .alarm(alarm)
  );

  typedef struct packed {
    logic [31:0] insn;
    logic        upd;
    logic        chk;
    logic        from_model;
    logic [31:0] opnd;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h00000013, 1'b0, 1'b0, 1'b0, 32'hDEADBEEF},
    '{32'h00A50533, 1'b0, 1'b0, 1'b0, 32'h00000000},
    '{32'hFE0598E3, 1'b1, 1'b0, 1'b0, 32'h12345678},
    '{32'h00000000, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF},
    '{32'hFFFFFFFF, 1'b0, 1'b1, 1'b1, 32'h00000000},
    '{32'h0040006F, 1'b1, 1'b0, 1'b0, 32'hFFFFFFFF},
    '{32'h00112023, 1'b0, 1'b1, 1'b1, 32'h00000000},
    '{32'h80000001, 1'b0, 1'b0, 1'b0, 32'hA5A5A5A5}
  };

  function automatic logic [31:0] ref_fold(logic [31:0] s, logic [31:0] w);
    logic fb;
    for (int i = 0; i < 32; i++) begin
      fb = s[0] ^ w[i];
      s  = s >> 1;
      if (fb) s = s ^ 32'h82F63B78;
    end
    return s;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic beat(logic [31:0] insn, logic upd, logic chk, logic [31:0] opnd);
    in_valid = 1'b1; in_insn = insn; in_is_update = upd;
    in_is_check = chk; in_operand = opnd;
    if (chk && opnd != model_sig) model_alarm = 1'b1;
    model_sig = ref_fold(model_sig, insn) ^ (upd ? opnd : 32'h0);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; in_is_update = 1'b0; in_is_check = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_sig = '0; model_alarm = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 sig in reset", sig_out, 32'h0);
    check("R1 alarm in reset", {31'h0, alarm}, 32'h0);
    check("R3 ready low in reset", {31'h0, in_ready}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R3 ready after reset", {31'h0, in_ready}, 32'h1);
  endtask

  initial begin
    logic [31:0] held;
    logic [31:0] op;
    do_reset();

    // table walk: R2 R4 R6 R9
    for (int k = 0; k < NV; k++) begin
      op = VECS[k].from_model ? model_sig : VECS[k].opnd;
      beat(VECS[k].insn, VECS[k].upd, VECS[k].chk, op);
      check("R2/R4/R6/R9 table sig", sig_out, model_sig);
      check("R5 table alarm", {31'h0, alarm}, {31'h0, model_alarm});
    end

    // R3 stall: garbage with valid low
    held = sig_out;
    in_insn = 32'hCAFEF00D; in_is_update = 1'b1; in_is_check = 1'b1;
    in_operand = 32'h0BADF00D;
    repeat (3) @(posedge clk);
    @(negedge clk);
    in_is_update = 1'b0; in_is_check = 1'b0;
    check("R3 stall hold", sig_out, held);
    check("R3 stall alarm", {31'h0, alarm}, 32'h0);

    // R8 both flags, matching operand
    beat(32'h00C58663, 1'b1, 1'b1, model_sig);
    check("R8 both match sig", sig_out, model_sig);
    check("R8 both match alarm", {31'h0, alarm}, 32'h0);

    // R5 mismatch, R6 fold of check word
    beat(32'h00B50463, 1'b0, 1'b1, model_sig ^ 32'h1);
    check("R5 mismatch alarm", {31'h0, alarm}, 32'h1);
    check("R6 check folds word", sig_out, model_sig);

    // R7 sticky through matching check and idle
    beat(32'h00008067, 1'b0, 1'b1, model_sig);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R7 alarm sticky", {31'h0, alarm}, 32'h1);
    check("R7 sig after match", sig_out, model_sig);

    // R1 reset clears alarm
    do_reset();

    // R8 both flags, mismatching operand: compare pre-state, patch after fold
    beat(32'h00000013, 1'b1, 1'b1, 32'h55AA55AA);
    check("R8 both miss alarm", {31'h0, alarm}, 32'h1);
    check("R8 both miss sig", sig_out, model_sig);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule